// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns a host-side packet stream into a complete Ethernet frame on a byte-wide media-independent transmit interface. A packet arrives as bytes with a valid/ready handshake. Start and end markers travel with the bytes. The packet already holds the destination address, optionally a source address, the length/type field and the data. The block adds everything that belongs on the wire but not in host memory. That means the preamble and start delimiter in front of the packet. It can also add a source address taken from the station-address inputs, zero padding for short frames, and the CRC-32 frame check sequence.

Four option bits travel with the first byte of each packet and apply to that packet only. They select automatic padding, source-address insertion, source-address replacement and FCS generation. Once a frame has started, the stream must keep pace with the transmitter. A missing byte in mid-frame cuts the frame short and raises an error pulse. Frames are separated by a programmable inter-packet gap. The gap is counted from the cycle transmit enable drops, with no carrier or collision input involved.

Top module: `ethtx_framer`

## Requirements
- R1: Every frame starts with `mii_tx_en` rising while `mii_txd` carries 0x55. PRE_LEN (default 7) bytes of 0x55 are followed by one 0xD5 byte. `mii_tx_en` then stays high without a break until the last byte of the frame.
- R2: After the 0xD5 byte, stream bytes appear unchanged and in arrival order, one per cycle. The first six stream bytes form the destination address.
- R3: With `opt_sa_ins` set, six station-address bytes are sent directly after the six destination bytes without consuming stream bytes. The byte order is `sta_addr_hi[15:8]`, `sta_addr_hi[7:0]`, `sta_addr_lo[31:24]`, `sta_addr_lo[23:16]`, `sta_addr_lo[15:8]`, `sta_addr_lo[7:0]`. If the stream ends within its first six bytes, nothing is inserted.
- R4: With `opt_sa_rep` set and `opt_sa_ins` clear, stream bytes 7 to 12 (those present) are consumed but sent as the station-address bytes in the R3 order. With both bits set, only insertion takes effect.
- R5: With `opt_fcs` set, four FCS bytes follow the last data or pad byte. The FCS is the complement of the reflected CRC-32 (polynomial 0x04C11DB7, all-ones start) over all bytes from the destination address through the padding, sent least-significant byte first. With `opt_fcs` clear, the frame ends with the last stream byte.
- R6: With `opt_pad` and `opt_fcs` both set, 0x00 bytes are added before the FCS until the frame, from destination address through FCS, is MIN_LEN (default 64) bytes long. With `opt_fcs` clear, `opt_pad` adds nothing. Frames already that long are not padded.
- R7: After `mii_tx_en` falls, it stays low for at least IPG (default 12) cycles. When the next packet is already waiting, it stays low for exactly IPG cycles.
- R8: The option bits are sampled only together with the start-marked byte; their values on later bytes have no effect. While no start-marked byte is offered, the block stays idle with `mii_tx_en` low.
- R9: If a stream byte is needed after the first one has been taken and `in_valid` is low, the frame ends: `mii_tx_en` falls and `tx_underrun` is high for exactly that one cycle. No padding or FCS is sent.
- R10: Bytes without the start marker that are offered while the block is idle are accepted and discarded without producing any output.
- R11: During and after reset, `mii_tx_en`, `mii_txd` and `tx_underrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte offered |
| in_ready | output | 1 | Stream byte taken at this edge when in_valid is high |
| in_data | input | 8 | Stream byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| opt_pad | input | 1 | Pad short frames (sampled with in_sop) |
| opt_sa_ins | input | 1 | Insert station address (sampled with in_sop) |
| opt_sa_rep | input | 1 | Replace source address (sampled with in_sop) |
| opt_fcs | input | 1 | Append generated FCS (sampled with in_sop) |
| sta_addr_hi | input | 16 | Upper station-address bytes |
| sta_addr_lo | input | 32 | Lower station-address bytes |
| mii_txd | output | 8 | Transmit byte |
| mii_tx_en | output | 1 | Transmit enable |
| tx_underrun | output | 1 | One-cycle pulse when a frame is cut short |

## Verification
The bench builds the block with MIN_LEN of 32 and IPG of 5, keeping the default 7-byte preamble. With these values a sweep over every packet length from 1 to 34 bytes, combined with all sixteen option combinations, crosses the padding threshold from both sides. The same sweep also covers packets that end inside the destination address or inside the replaced source field. A stall sweep cuts frames at every stream position from the first destination byte to past the source field, with and without insertion and replacement. Back-to-back packets show the gap at its exact minimum.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_DA,
    ST_SAI,
    ST_SAR,
    ST_BODY,
    ST_PAD,
    ST_FCS,
    ST_GAP
  } tx_state_e;

  typedef struct packed {
    logic pad;
    logic ins;
    logic rep;
    logic fcs;
  } tx_opt_t;

  localparam logic [7:0]  PRE_BYTE     = 8'h55;
  localparam logic [7:0]  SFD_BYTE     = 8'hD5;
  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam int          ADDR_BYTES   = 6;
  localparam int          FCS_BYTES    = 4;

  // One byte of the reflected CRC-32, bit 0 of the byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REV) : (r >> 1);
    end
    return r;
  endfunction

  // Station-address byte i in wire order.
  function automatic logic [7:0] sta_byte(input logic [15:0] hi, input logic [31:0] lo,
                                          input logic [2:0] i);
    logic [7:0] b;
    case (i)
      3'd0:    b = hi[15:8];
      3'd1:    b = hi[7:0];
      3'd2:    b = lo[31:24];
      3'd3:    b = lo[23:16];
      3'd4:    b = lo[15:8];
      default: b = lo[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ethtx_crc32.sv
module ethtx_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  import ethtx_pkg::*;

  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init) begin
      crc_d = '1;
    end else if (en) begin
      crc_d = crc32_step(crc_q, din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else begin
      crc_q <= crc_d;
    end
  end

endmodule

// File: rtl/ethtx_gap_timer.sv
module ethtx_gap_timer #(
  parameter int IPG = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int             CNT_W   = $clog2(IPG + 1);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(IPG - 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(IPG - 2);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_SAT) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_SAT;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // Leaving the gap state at count IPG-2 plus one idle cycle gives IPG low cycles.
  assign expired = (cnt_q >= CNT_END);

endmodule

// File: rtl/ethtx_framer.sv
module ethtx_framer #(
  parameter int PRE_LEN = 7,
  parameter int MIN_LEN = 64,
  parameter int IPG     = 12,
  parameter int LEN_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic        opt_pad,
  input  logic        opt_sa_ins,
  input  logic        opt_sa_rep,
  input  logic        opt_fcs,
  input  logic [15:0] sta_addr_hi,
  input  logic [31:0] sta_addr_lo,
  output logic [7:0]  mii_txd,
  output logic        mii_tx_en,
  output logic        tx_underrun
);
  import ethtx_pkg::*;

  localparam int               IDX_W     = (PRE_LEN > 8) ? $clog2(PRE_LEN) : 3;
  localparam logic [IDX_W-1:0] PRE_LAST  = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_BYTES - 1);
  localparam logic [IDX_W-1:0] FCS_LAST  = IDX_W'(FCS_BYTES - 1);
  localparam logic [LEN_W-1:0] PAD_TGT   = LEN_W'(MIN_LEN - FCS_BYTES);

  tx_state_e        state_q, state_d, tail_st;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d, len_inc;
  tx_opt_t          opt_q, opt_d;
  logic [7:0]       txd_q, txd_d;
  logic             txen_q, txen_d;
  logic             err_q, err_d;

  logic             stream_st, underrun;
  logic             crc_init, crc_en;
  logic [31:0]      crc_q, fcs_word;
  logic [7:0]       sta_b, fcs_b;
  logic             gap_clr, gap_done;

  ethtx_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (crc_init),
    .en    (crc_en),
    .din   (txd_d),
    .crc_q (crc_q)
  );

  ethtx_gap_timer #(.IPG(IPG)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (gap_clr),
    .expired (gap_done)
  );

  assign stream_st = (state_q == ST_DA) || (state_q == ST_SAR) || (state_q == ST_BODY);
  assign underrun  = stream_st && !in_valid;
  assign in_ready  = stream_st || ((state_q == ST_IDLE) && !in_sop);
  assign len_inc   = len_q + 1'b1;
  assign fcs_word  = ~crc_q;
  assign fcs_b     = fcs_word[{idx_q[1:0], 3'b000} +: 8];
  assign sta_b     = sta_byte(sta_addr_hi, sta_addr_lo, idx_q[2:0]);

  // Where the frame goes once the stream part has ended.
  always_comb begin
    if (opt_q.fcs && opt_q.pad && (len_inc < PAD_TGT)) begin
      tail_st = ST_PAD;
    end else if (opt_q.fcs) begin
      tail_st = ST_FCS;
    end else begin
      tail_st = ST_GAP;
    end
  end

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    len_d    = len_q;
    opt_d    = opt_q;
    txd_d    = 8'h00;
    txen_d   = 1'b0;
    err_d    = 1'b0;
    crc_init = 1'b0;
    crc_en   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (in_valid && in_sop) begin
          state_d   = ST_PRE;
          idx_d     = '0;
          opt_d.pad = opt_pad;
          opt_d.ins = opt_sa_ins;
          opt_d.rep = opt_sa_rep && !opt_sa_ins;
          opt_d.fcs = opt_fcs;
        end
      end
      ST_PRE: begin
        txd_d  = PRE_BYTE;
        txen_d = 1'b1;
        if (idx_q == PRE_LAST) begin
          state_d = ST_SFD;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_SFD: begin
        txd_d    = SFD_BYTE;
        txen_d   = 1'b1;
        crc_init = 1'b1;
        state_d  = ST_DA;
        idx_d    = '0;
        len_d    = '0;
      end
      ST_DA, ST_SAR, ST_BODY: begin
        if (underrun) begin
          state_d = ST_GAP;
          err_d   = 1'b1;
        end else begin
          txd_d  = (state_q == ST_SAR) ? sta_b : in_data;
          txen_d = 1'b1;
          crc_en = 1'b1;
          len_d  = len_inc;
          if (in_eop) begin
            state_d = tail_st;
            idx_d   = '0;
          end else if (state_q != ST_BODY) begin
            if (idx_q == ADDR_LAST) begin
              idx_d = '0;
              if ((state_q == ST_DA) && opt_q.ins) begin
                state_d = ST_SAI;
              end else if ((state_q == ST_DA) && opt_q.rep) begin
                state_d = ST_SAR;
              end else begin
                state_d = ST_BODY;
              end
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
      end
      ST_SAI: begin
        txd_d  = sta_b;
        txen_d = 1'b1;
        crc_en = 1'b1;
        len_d  = len_inc;
        if (idx_q == ADDR_LAST) begin
          state_d = ST_BODY;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_PAD: begin
        txd_d  = 8'h00;
        txen_d = 1'b1;
        crc_en = 1'b1;
        len_d  = len_inc;
        if (len_inc >= PAD_TGT) begin
          state_d = ST_FCS;
          idx_d   = '0;
        end
      end
      ST_FCS: begin
        txd_d  = fcs_b;
        txen_d = 1'b1;
        if (idx_q == FCS_LAST) begin
          state_d = ST_GAP;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_done) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign gap_clr = (state_d == ST_GAP) && (state_q != ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      len_q   <= '0;
      opt_q   <= '0;
      txd_q   <= 8'h00;
      txen_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      opt_q   <= opt_d;
      txd_q   <= txd_d;
      txen_q  <= txen_d;
      err_q   <= err_d;
    end
  end

  assign mii_txd     = txd_q;
  assign mii_tx_en   = txen_q;
  assign tx_underrun = err_q;

endmodule

// File: rtl/ethtx_framer_chk.sv
module ethtx_framer_chk #(
  parameter int PRE_LEN = 7,
  parameter int IPG     = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] mii_txd,
  input logic       mii_tx_en,
  input logic       tx_underrun
);
  localparam logic [7:0]  HI_SAT  = 8'd255;
  localparam logic [7:0]  PRE_N   = 8'(PRE_LEN);
  localparam logic [15:0] LO_SAT  = 16'(IPG);

  logic [7:0]  hi_cnt;
  logic [15:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= LO_SAT;
    end else begin
      if (mii_tx_en) begin
        hi_cnt <= (hi_cnt == HI_SAT) ? hi_cnt : hi_cnt + 1'b1;
        lo_cnt <= '0;
      end else begin
        hi_cnt <= '0;
        lo_cnt <= (lo_cnt >= LO_SAT) ? lo_cnt : lo_cnt + 1'b1;
      end
    end
  end

  assert_preamble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_tx_en && (hi_cnt < PRE_N)) |-> (mii_txd == 8'h55));

  assert_sfd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_tx_en && (hi_cnt == PRE_N)) |-> (mii_txd == 8'hD5));

  assert_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_tx_en) |-> (lo_cnt >= LO_SAT));

  assert_err_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> (!mii_tx_en && $past(mii_tx_en)));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> !tx_underrun);

endmodule

bind ethtx_framer ethtx_framer_chk #(.PRE_LEN(PRE_LEN), .IPG(IPG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mii_txd     (mii_txd),
  .mii_tx_en   (mii_tx_en),
  .tx_underrun (tx_underrun)
);

// File: tb/test_ethtx_framer.sv
module test_ethtx_framer;
  localparam int PRE_LEN = 7;
  localparam int MIN_LEN = 32;
  localparam int IPG     = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_sop, in_eop;
  logic [7:0]  in_data;
  logic        opt_pad, opt_sa_ins, opt_sa_rep, opt_fcs;
  logic [15:0] sta_addr_hi;
  logic [31:0] sta_addr_lo;
  logic [7:0]  mii_txd;
  logic        mii_tx_en, tx_underrun;

  always #5 clk = ~clk;

  ethtx_framer #(.PRE_LEN(PRE_LEN), .MIN_LEN(MIN_LEN), .IPG(IPG)) i_ethtx_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .opt_pad(opt_pad), .opt_sa_ins(opt_sa_ins),
    .opt_sa_rep(opt_sa_rep), .opt_fcs(opt_fcs), .sta_addr_hi(sta_addr_hi),
    .sta_addr_lo(sta_addr_lo), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
    .tx_underrun(tx_underrun)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Expected-frame bookkeeping
  logic [7:0] exp_q[$];
  int         exp_len[$];
  string      exp_tag[$];
  int         pending = 0;
  logic [7:0] pkt[64];
  logic [7:0] sa[6];

  function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      c = c ^ {24'h0, q[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build_expected(input int len, input bit pad, input bit ins, input bit rep,
                                input bit fcs, input bit trunc, input string tag);
    logic [7:0] body[$];
    logic [31:0] f;
    bit rep_e;
    rep_e = rep && !ins;
    for (int i = 0; i < len; i++) begin
      if (ins && i == 6) for (int j = 0; j < 6; j++) body.push_back(sa[j]);
      if (rep_e && i >= 6 && i < 12) body.push_back(sa[i-6]);
      else body.push_back(pkt[i]);
    end
    if (trunc) begin
      if (ins && len == 6) for (int j = 0; j < 6; j++) body.push_back(sa[j]);
    end else begin
      if (pad && fcs) while (body.size() < MIN_LEN - 4) body.push_back(8'h00);
      if (fcs) begin
        f = ref_crc(body);
        for (int j = 0; j < 4; j++) body.push_back(f[8*j +: 8]);
      end
    end
    for (int i = 0; i < PRE_LEN; i++) exp_q.push_back(8'h55);
    exp_q.push_back(8'hD5);
    foreach (body[i]) exp_q.push_back(body[i]);
    exp_len.push_back(PRE_LEN + 1 + body.size());
    exp_tag.push_back(tag);
    pending++;
  endtask

  // Output monitor
  logic [7:0] cap[$];
  bit         prev_en = 0;
  int         low_cnt = 0;
  int         last_gap = 0;
  int         frames_done = 0;
  int         err_seen = 0;

  task automatic compare_frame();
    int L; string tag; int bad; logic [7:0] e; logic [7:0] a; logic [7:0] be; logic [7:0] ba;
    if (exp_len.size() == 0) begin
      check(0, "R10", "unexpected frame length", cap.size(), 0);
    end else begin
      L = exp_len.pop_front();
      tag = exp_tag.pop_front();
      bad = -1; be = 0; ba = 0;
      for (int i = 0; i < L; i++) begin
        e = exp_q.pop_front();
        a = (i < cap.size()) ? cap[i] : 8'hxx;
        if (bad < 0 && (i >= cap.size() || a !== e)) begin bad = i; be = e; ba = a; end
      end
      check(cap.size() == L, tag, "frame length", cap.size(), L);
      check(bad < 0, tag, $sformatf("frame byte %0d", bad), ba, be);
      pending--;
    end
    cap.delete();
    frames_done++;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mii_tx_en) begin
        if (!prev_en) begin
          last_gap = low_cnt;
          if (frames_done > 0) check(low_cnt >= IPG, "R7", "gap before frame", low_cnt, IPG);
        end
        cap.push_back(mii_txd);
        low_cnt = 0;
      end else begin
        low_cnt++;
      end
      if (prev_en && !mii_tx_en) compare_frame();
      if (tx_underrun) begin
        err_seen++;
        check(!mii_tx_en && prev_en, "R9", "pulse at end of frame", mii_tx_en, 0);
      end
      prev_en = mii_tx_en;
    end
  end

  // Stream driver
  task automatic push(input logic [7:0] d, input bit sop, input bit eop,
                      input bit pad, input bit ins, input bit rep, input bit fcs);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sop = sop; in_eop = eop;
    opt_pad = pad; opt_sa_ins = ins; opt_sa_rep = rep; opt_fcs = fcs;
    forever begin
      #4;
      if (in_ready) begin @(posedge clk); break; end
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic send_pkt(input int len, input bit pad, input bit ins, input bit rep,
                          input bit fcs, input int stall_k, input int seed);
    int e0;
    bit trunc;
    trunc = (stall_k < len);
    for (int i = 0; i < len; i++) pkt[i] = 8'((i * 37 + seed * 11 + 3) & 255);
    build_expected(trunc ? stall_k : len, pad, ins, rep, fcs, trunc,
                   trunc ? "R9" : "R2 R3 R4 R5 R6 R8");
    e0 = err_seen;
    for (int i = 0; i < len; i++) begin
      if (i == stall_k) begin
        @(negedge clk);
        in_valid = 0;
        wait (err_seen == e0 + 1);
      end
      if (i == 0) push(pkt[i], 1'b1, i == len - 1, pad, ins, rep, fcs);
      else        push(pkt[i], 1'b0, i == len - 1, ~pad, ~ins, ~rep, ~fcs);
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0, e0;
    rst_n = 0;
    in_valid = 0; in_sop = 0; in_eop = 0; in_data = 0;
    opt_pad = 0; opt_sa_ins = 0; opt_sa_rep = 0; opt_fcs = 0;
    sta_addr_hi = 16'hA1B2;
    sta_addr_lo = 32'hC3D4_E5F6;
    sa[0] = 8'hA1; sa[1] = 8'hB2; sa[2] = 8'hC3; sa[3] = 8'hD4; sa[4] = 8'hE5; sa[5] = 8'hF6;
    repeat (3) @(negedge clk);
    check(mii_tx_en == 0, "R11", "tx_en in reset", mii_tx_en, 0);
    check(mii_txd == 0, "R11", "txd in reset", mii_txd, 0);
    check(tx_underrun == 0, "R11", "underrun in reset", tx_underrun, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(mii_tx_en == 0 && mii_txd == 0, "R11", "state after reset", mii_tx_en, 0);

    // Nothing offered: stays idle
    repeat (20) @(negedge clk);
    check(mii_tx_en == 0 && frames_done == 0, "R8", "idle without start byte", frames_done, 0);

    // Non-start bytes while idle are discarded
    for (int i = 0; i < 5; i++) push(8'(i + 9), 1'b0, i == 4, 1'b1, 1'b1, 1'b0, 1'b1);
    @(negedge clk); in_valid = 0; in_eop = 0;
    repeat (15) @(negedge clk);
    check(frames_done == 0 && mii_tx_en == 0, "R10", "drained bytes produce no frame",
          frames_done, 0);

    // Sweep lengths and option combinations
    for (int len = 1; len <= 34; len++) begin
      for (int o = 0; o < 16; o++) begin
        send_pkt(len, o[0], o[1], o[2], o[3], 1000, len * 16 + o);
        wait (pending == 0);
      end
    end

    // Back-to-back: gap at minimum
    send_pkt(20, 1'b1, 1'b0, 1'b0, 1'b1, 1000, 3);
    send_pkt(15, 1'b0, 1'b1, 1'b0, 1'b1, 1000, 4);
    wait (pending == 0);
    check(last_gap == IPG, "R7", "back-to-back gap", last_gap, IPG);

    // Underrun at every position through the address fields
    for (int k = 1; k <= 13; k++) begin
      for (int o = 0; o < 3; o++) begin
        e0 = err_seen;
        send_pkt(20, 1'b1, o == 1, o == 2, 1'b1, k, k * 3 + o);
        wait (pending == 0);
        f0 = frames_done;
        repeat (IPG + 6) @(negedge clk);
        check(err_seen == e0 + 1, "R9", "one underrun pulse", err_seen - e0, 1);
        check(frames_done == f0 && mii_tx_en == 0, "R10", "rest of cut packet discarded",
              frames_done - f0, 0);
      end
    end

    // Normal frame after underrun
    send_pkt(10, 1'b1, 1'b1, 1'b0, 1'b1, 1000, 77);
    wait (pending == 0);
    check(exp_q.size() == 0, "R2", "all expected bytes consumed", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule